// File: doc/BRIEF.md
# Control-Track Pulse Writer

This block produces the record-side control-track waveform for a tape transport, one pulse per data bit, with the bit carried by the pulse's duty cycle. Software writes a bit into a one-deep write register. The next anchor event then starts a pulse. An anchor event is either the periodic reference tick or the rising edge of the previously recorded track, depending on the mode. The pulse's leading edge and its falling slope are timed in clock cycles from that anchor. The values come from five timing inputs, and the written bit picks which pair sets the falling slope.

The falling slope is reported as two strobes, slope start and slope end, for an external waveform shaper. The digital waveform output is high from the leading edge up to the end of the slope. A read-back flag shows the inverse of the bit in flight while a pulse is running. When idle, it shows the last written bit. A mark-record mode writes a single long-duty pulse from a zero write.

Top module: `ctp_writer`

## Requirements
- R1: After a synchronous reset, `wave_o`, `slope_start_o`, `slope_end_o` and `flag_rd_o` are 0 and no bit is pending.
- R2: Each bit write arms exactly one pulse. An anchor with no bit pending starts nothing. A pending bit with no anchor keeps `wave_o` low indefinitely and stays pending.
- R3: `mode_i` encoding is 2'b00 record, 2'b01 rewrite, 2'b10 mark-record and 2'b11 inert. Record and mark-record anchor on `ref_tick_i` and ignore `trk_rise_i`. Rewrite anchors on `trk_rise_i` and ignores `ref_tick_i`. Inert ignores both and keeps the pending bit.
- R4: Record mode, anchor sampled at clock edge E: `wave_o` goes high after edge E+`t_lead_i` and low after edge E+end. `slope_start_o` is high for the one cycle after edge E+start. `slope_end_o` is high for the one cycle after edge E+end.
- R5: Bit 0 takes start/end from `t_f0_start_i`/`t_f0_end_i`. Bit 1 takes them from `t_f1_start_i`/`t_f1_end_i`.
- R6: Rewrite mode ignores `t_lead_i`: `wave_o` is high from the cycle after the anchor edge E. The slope strobes follow R4 and R5.
- R7: Mark-record mode, bit 0: the leading edge is at `t_lead_i`, and both strobes and the fall are at `t_f0_end_i`. Mark-record mode, bit 1: the pending bit is consumed at the anchor and no pulse is produced.
- R8: While a pulse runs, `flag_rd_o` reads the inverse of the bit being written. When idle, it reads the last written bit.
- R9: During a pulse, a new anchor is ignored. A bit write only arms the following pulse. Timing inputs changed mid-pulse do not alter it, because they are captured at the anchor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_tick_i | input | 1 | Periodic reference tick, one-cycle pulse |
| trk_rise_i | input | 1 | Rising edge of the recorded track, one-cycle pulse |
| mode_i | input | 2 | Mode select (R3) |
| t_lead_i | input | TW | Anchor to leading-edge delay |
| t_f0_start_i | input | TW | Slope start, bit 0 |
| t_f0_end_i | input | TW | Slope end, bit 0 |
| t_f1_start_i | input | TW | Slope start, bit 1 |
| t_f1_end_i | input | TW | Slope end, bit 1 |
| bit_wr_i | input | 1 | Write strobe for the bit register |
| bit_val_i | input | 1 | Bit value written |
| wave_o | output | 1 | Digital control-track waveform |
| slope_start_o | output | 1 | Falling-slope start strobe |
| slope_end_o | output | 1 | Falling-slope end strobe |
| flag_rd_o | output | 1 | Read-back flag (R8) |

## Verification
The anchor is sampled on one clock edge, and every result is then counted from that edge. The waveform edge and the strobes for a delay of d show up in the cycle after edge E+d, and the read-back flag changes in the cycle after E. The bench drives the anchor for exactly one cycle and starts its cycle index k=0 at the first falling clock edge after E. It then records the first k at which each output is seen, so the measured index must equal the programmed delay exactly. Bit writes and anchors issued mid-pulse are placed at chosen k values, and their effects are checked both inside the running pulse and after it ends.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

    typedef enum logic [1:0] {
        MODE_REC  = 2'b00,
        MODE_REW  = 2'b01,
        MODE_MARK = 2'b10,
        MODE_OFF  = 2'b11
    } ctp_mode_e;

    // Anchor taken from the internal reference tick
    function automatic logic anchors_on_ref(ctp_mode_e m);
        return (m == MODE_REC) || (m == MODE_MARK);
    endfunction

    // Anchor taken from the recorded-track rising edge
    function automatic logic anchors_on_trk(ctp_mode_e m);
        return (m == MODE_REW);
    endfunction

    // Leading edge delayed by the lead timing value
    function automatic logic uses_lead(ctp_mode_e m);
        return (m == MODE_REC) || (m == MODE_MARK);
    endfunction

endpackage

// File: rtl/ctp_anchor_sel.sv
module ctp_anchor_sel
    import ctp_pkg::*;
(
    input  ctp_mode_e mode,
    input  logic      ref_tick,
    input  logic      trk_rise,
    output logic      anchor
);
    always_comb begin
        anchor = 1'b0;
        if (anchors_on_ref(mode))
            anchor = ref_tick;
        else if (anchors_on_trk(mode))
            anchor = trk_rise;
    end
endmodule

// File: rtl/ctp_bit_store.sv
module ctp_bit_store (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wr_val,
    input  logic consume,
    output logic pending,
    output logic bit_q
);
    // A write in the same cycle as a consume arms the next pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            bit_q   <= 1'b0;
        end else begin
            if (wr) begin
                pending <= 1'b1;
                bit_q   <= wr_val;
            end else if (consume) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ctp_timing_sel.sv
module ctp_timing_sel
    import ctp_pkg::*;
#(
    parameter int TW = 8
) (
    input  ctp_mode_e       mode,
    input  logic            bit_v,
    input  logic [TW-1:0]   t_lead,
    input  logic [TW-1:0]   t_f0_start,
    input  logic [TW-1:0]   t_f0_end,
    input  logic [TW-1:0]   t_f1_start,
    input  logic [TW-1:0]   t_f1_end,
    output logic [TW-1:0]   sel_lead,
    output logic [TW-1:0]   sel_start,
    output logic [TW-1:0]   sel_end,
    output logic            sel_skip
);
    logic [TW-1:0] pair_start;
    logic [TW-1:0] pair_end;

    assign pair_start = bit_v ? t_f1_start : t_f0_start;
    assign pair_end   = bit_v ? t_f1_end   : t_f0_end;

    always_comb begin
        sel_lead  = uses_lead(mode) ? t_lead : '0;
        sel_start = pair_start;
        sel_end   = pair_end;
        sel_skip  = 1'b0;
        unique case (mode)
            MODE_REC, MODE_REW: ;
            MODE_MARK: begin
                sel_start = t_f0_end;
                sel_end   = t_f0_end;
                sel_skip  = bit_v;
            end
            default: begin
                sel_start = '0;
                sel_end   = '0;
                sel_skip  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ctp_pulse_seq.sv
module ctp_pulse_seq #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          anchor,
    input  logic          pending,
    input  logic          bit_v,
    input  logic [TW-1:0] sel_lead,
    input  logic [TW-1:0] sel_start,
    input  logic [TW-1:0] sel_end,
    input  logic          sel_skip,
    output logic          consume,
    output logic          run,
    output logic          cur_bit,
    output logic          wave,
    output logic          slope_start,
    output logic          slope_end
);
    typedef struct packed {
        logic [TW-1:0] lead;
        logic [TW-1:0] t_s;
        logic [TW-1:0] t_e;
    } cap_t;

    cap_t          cap_q;
    logic [TW-1:0] cnt_q;
    logic          start;

    assign consume = anchor && pending && !run;
    assign start   = consume && !sel_skip;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            cnt_q   <= '0;
            cap_q   <= '0;
            cur_bit <= 1'b0;
        end else if (start) begin
            run     <= 1'b1;
            cnt_q   <= '0;
            cap_q   <= '{lead: sel_lead, t_s: sel_start, t_e: sel_end};
            cur_bit <= bit_v;
        end else if (run) begin
            if (cnt_q == cap_q.t_e)
                run <= 1'b0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wave        = run && (cnt_q >= cap_q.lead) && (cnt_q < cap_q.t_e);
    assign slope_start = run && (cnt_q == cap_q.t_s);
    assign slope_end   = run && (cnt_q == cap_q.t_e);
endmodule

// File: rtl/ctp_writer.sv
module ctp_writer
    import ctp_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          ref_tick_i,
    input  logic          trk_rise_i,
    input  logic [1:0]    mode_i,
    input  logic [TW-1:0] t_lead_i,
    input  logic [TW-1:0] t_f0_start_i,
    input  logic [TW-1:0] t_f0_end_i,
    input  logic [TW-1:0] t_f1_start_i,
    input  logic [TW-1:0] t_f1_end_i,
    input  logic          bit_wr_i,
    input  logic          bit_val_i,
    output logic          wave_o,
    output logic          slope_start_o,
    output logic          slope_end_o,
    output logic          flag_rd_o
);
    ctp_mode_e     mode_e;
    logic          anchor;
    logic          pending;
    logic          bit_q;
    logic          consume;
    logic          seq_run;
    logic          cur_bit;
    logic [TW-1:0] sel_lead;
    logic [TW-1:0] sel_start;
    logic [TW-1:0] sel_end;
    logic          sel_skip;

    assign mode_e = ctp_mode_e'(mode_i);

    ctp_anchor_sel u_anchor (
        .mode     (mode_e),
        .ref_tick (ref_tick_i),
        .trk_rise (trk_rise_i),
        .anchor   (anchor)
    );

    ctp_bit_store u_bit (
        .clk     (clk_i),
        .rst     (rst_i),
        .wr      (bit_wr_i),
        .wr_val  (bit_val_i),
        .consume (consume),
        .pending (pending),
        .bit_q   (bit_q)
    );

    ctp_timing_sel #(.TW(TW)) u_tsel (
        .mode       (mode_e),
        .bit_v      (bit_q),
        .t_lead     (t_lead_i),
        .t_f0_start (t_f0_start_i),
        .t_f0_end   (t_f0_end_i),
        .t_f1_start (t_f1_start_i),
        .t_f1_end   (t_f1_end_i),
        .sel_lead   (sel_lead),
        .sel_start  (sel_start),
        .sel_end    (sel_end),
        .sel_skip   (sel_skip)
    );

    ctp_pulse_seq #(.TW(TW)) u_seq (
        .clk         (clk_i),
        .rst         (rst_i),
        .anchor      (anchor),
        .pending     (pending),
        .bit_v       (bit_q),
        .sel_lead    (sel_lead),
        .sel_start   (sel_start),
        .sel_end     (sel_end),
        .sel_skip    (sel_skip),
        .consume     (consume),
        .run         (seq_run),
        .cur_bit     (cur_bit),
        .wave        (wave_o),
        .slope_start (slope_start_o),
        .slope_end   (slope_end_o)
    );

    // Inverse of the bit in flight; the stored bit when idle
    assign flag_rd_o = seq_run ? ~cur_bit : bit_q;
endmodule

// File: rtl/ctp_writer_chk.sv
module ctp_writer_chk
    import ctp_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       ref_tick_i,
    input logic       trk_rise_i,
    input logic [1:0] mode_i,
    input logic       run,
    input logic       wave_o,
    input logic       slope_start_o,
    input logic       slope_end_o,
    input logic       flag_rd_o
);
    // R2: a pulse only begins on an anchor input
    p_start_on_anchor_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(run) |-> $past(ref_tick_i || trk_rise_i));

    // R4: nothing drives the outputs outside a pulse
    p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !run |-> (!wave_o && !slope_start_o && !slope_end_o));

    // R4: the pulse is over one cycle after the end strobe
    p_end_closes_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        slope_end_o |=> !run);

    // R6: in rewrite mode the waveform is up from the first cycle
    p_rewrite_lead_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(run) && $past(mode_i) == MODE_REW) |-> (wave_o || slope_end_o));

    // R9: flag holds steady for the whole pulse
    p_flag_steady_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (run && $past(run)) |-> $stable(flag_rd_o));
endmodule

bind ctp_writer ctp_writer_chk u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .ref_tick_i    (ref_tick_i),
    .trk_rise_i    (trk_rise_i),
    .mode_i        (mode_i),
    .run           (seq_run),
    .wave_o        (wave_o),
    .slope_start_o (slope_start_o),
    .slope_end_o   (slope_end_o),
    .flag_rd_o     (flag_rd_o)
);

// File: tb/ctp_writer_tb_top.sv
module ctp_writer_tb_top;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_tick = 1'b0;
    logic          trk_rise = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [TW-1:0] t_lead = 8'd3;
    logic [TW-1:0] t_f0s = 8'd10;
    logic [TW-1:0] t_f0e = 8'd14;
    logic [TW-1:0] t_f1s = 8'd20;
    logic [TW-1:0] t_f1e = 8'd25;
    logic          bit_wr = 1'b0;
    logic          bit_val = 1'b0;
    logic          wave_o, slope_start_o, slope_end_o, flag_rd_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ctp_writer #(.TW(TW)) dut_i (
        .clk_i(clk), .rst_i(rst), .ref_tick_i(ref_tick), .trk_rise_i(trk_rise),
        .mode_i(mode), .t_lead_i(t_lead), .t_f0_start_i(t_f0s), .t_f0_end_i(t_f0e),
        .t_f1_start_i(t_f1s), .t_f1_end_i(t_f1e), .bit_wr_i(bit_wr), .bit_val_i(bit_val),
        .wave_o(wave_o), .slope_start_o(slope_start_o), .slope_end_o(slope_end_o),
        .flag_rd_o(flag_rd_o)
    );

    typedef struct packed {
        logic [1:0] md;
        logic       bv;
        logic [7:0] r1, r2, r3, r4, r5;
        int         e_rise, e_ss, e_se, e_flag;
    } vec_t;

    // expected indices are cycles after the anchor edge
    localparam vec_t VEC [6] = '{
        '{2'b00, 1'b0, 8'd3, 8'd10, 8'd14, 8'd20, 8'd25,  3, 10, 14, 1},
        '{2'b00, 1'b1, 8'd3, 8'd10, 8'd14, 8'd20, 8'd25,  3, 20, 25, 0},
        '{2'b01, 1'b0, 8'd7, 8'd10, 8'd14, 8'd20, 8'd25,  0, 10, 14, 1},
        '{2'b01, 1'b1, 8'd7, 8'd10, 8'd14, 8'd20, 8'd25,  0, 20, 25, 0},
        '{2'b10, 1'b0, 8'd3, 8'd10, 8'd22, 8'd5,  8'd8,   3, 22, 22, 1},
        '{2'b00, 1'b1, 8'd0, 8'd4,  8'd6,  8'd9,  8'd12,  0,  9, 12, 0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_bit(input logic v);
        @(negedge clk); bit_wr = 1'b1; bit_val = v;
        @(negedge clk); bit_wr = 1'b0;
    endtask

    task automatic fire(input logic use_trk);
        @(negedge clk);
        if (use_trk) trk_rise = 1'b1; else ref_tick = 1'b1;
        @(negedge clk);
        trk_rise = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic observe(input int lim, output int r_k, output int ss_k,
                           output int se_k, output int fall_k, output int fl);
        r_k = -1; ss_k = -1; se_k = -1; fall_k = -1; fl = -1;
        for (int k = 0; k < lim; k++) begin
            if (wave_o && r_k < 0) r_k = k;
            if (!wave_o && r_k >= 0 && fall_k < 0) fall_k = k;
            if (slope_start_o && ss_k < 0) ss_k = k;
            if (slope_end_o && se_k < 0) se_k = k;
            if (k == 1) fl = int'(flag_rd_o);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int r, ss, se, fa, fl;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 wave", int'(wave_o), 0);
        chk("R1 strobes", int'(slope_start_o | slope_end_o), 0);
        chk("R1 flag", int'(flag_rd_o), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1/R2: no pending bit after reset, anchor starts nothing
        fire(1'b0);
        observe(30, r, ss, se, fa, fl);
        chk("R2 no write no pulse", se, -1);

        // table of vectors
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mode = VEC[i].md; t_lead = VEC[i].r1; t_f0s = VEC[i].r2;
            t_f0e = VEC[i].r3; t_f1s = VEC[i].r4; t_f1e = VEC[i].r5;
            wr_bit(VEC[i].bv);
            fire(VEC[i].md == 2'b01);
            observe(40, r, ss, se, fa, fl);
            chk("R4 R6 rise", r, VEC[i].e_rise);
            chk("R5 R7 slope start", ss, VEC[i].e_ss);
            chk("R5 R7 slope end", se, VEC[i].e_se);
            chk("R4 fall", fa, VEC[i].e_se);
            chk("R8 flag inverse", fl, VEC[i].e_flag);
        end

        @(negedge clk);
        mode = 2'b00; t_lead = 8'd3; t_f0s = 8'd10; t_f0e = 8'd14;
        t_f1s = 8'd20; t_f1e = 8'd25;

        // R2: pending bit without anchor stays low, then is used
        wr_bit(1'b0);
        observe(60, r, ss, se, fa, fl);
        chk("R2 no anchor no pulse", r, -1);
        fire(1'b0);
        observe(40, r, ss, se, fa, fl);
        chk("R2 pending kept", r, 3);

        // R3: rewrite ignores ref tick, takes track edge
        mode = 2'b01;
        wr_bit(1'b0);
        fire(1'b0);
        observe(30, r, ss, se, fa, fl);
        chk("R3 rewrite ignores ref", se, -1);
        fire(1'b1);
        observe(30, r, ss, se, fa, fl);
        chk("R3 rewrite on track", se, 14);

        // R3: record ignores track edge
        mode = 2'b00;
        wr_bit(1'b1);
        fire(1'b1);
        observe(30, r, ss, se, fa, fl);
        chk("R3 record ignores track", se, -1);
        fire(1'b0);
        observe(40, r, ss, se, fa, fl);
        chk("R3 record on ref", se, 25);

        // R3: inert mode ignores both, keeps pending
        mode = 2'b11;
        wr_bit(1'b0);
        fire(1'b0);
        fire(1'b1);
        observe(30, r, ss, se, fa, fl);
        chk("R3 inert", se, -1);
        mode = 2'b00;
        fire(1'b0);
        observe(30, r, ss, se, fa, fl);
        chk("R3 inert kept pending", se, 14);

        // R7: mark with bit 1 consumes and writes nothing
        mode = 2'b10;
        wr_bit(1'b1);
        fire(1'b0);
        observe(40, r, ss, se, fa, fl);
        chk("R7 mark bit1 no pulse", r, -1);
        mode = 2'b00;
        fire(1'b0);
        observe(40, r, ss, se, fa, fl);
        chk("R7 mark bit1 consumed", se, -1);

        // R9: write, anchor and timing change inside a pulse
        wr_bit(1'b0);
        fire(1'b0);
        se = -1; fl = -1;
        for (int k = 0; k < 40; k++) begin
            if (k == 5) begin
                bit_wr = 1'b1; bit_val = 1'b1; ref_tick = 1'b1; t_f0e = 8'd30;
            end
            if (k == 6) begin
                bit_wr = 1'b0; ref_tick = 1'b0;
            end
            if (slope_end_o && se < 0) se = k;
            if (k == 8) fl = int'(flag_rd_o);
            @(negedge clk);
        end
        chk("R9 timing captured", se, 14);
        chk("R8 flag during pulse", fl, 1);
        chk("R8 flag idle shows stored", int'(flag_rd_o), 1);
        t_f0e = 8'd14;
        observe(40, r, ss, se, fa, fl);
        chk("R9 mid-pulse anchor ignored", r, -1);
        fire(1'b0);
        observe(40, r, ss, se, fa, fl);
        chk("R5 R9 next pulse uses bit1 start", ss, 20);
        chk("R5 R9 next pulse uses bit1 end", se, 25);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule